// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects interrupt requests from many sources and presents them to a processor as one request line per bank. Each bank holds 32 sources. A source that is asserted is captured in that bank's status register. The status is masked by a per-bank enable register, and the result is readable as a pending word. If any pending bit is set, the bank raises its own CPU request line one clock later. Bank 0 drives the lowest line, and the other banks follow in order.

Software reaches the banks through a plain 32-bit register port with a byte address. Every bank has the same layout, and the banks are placed at a fixed stride of 0x28 bytes.

Software acknowledges a source by writing a one to its status bit. Software can also raise a source itself by writing a one to the same bit of a set register. A per-source mode register chooses between two behaviours: a latched status bit that stays set until cleared, and a bit that simply follows its input. Each bank also outputs the number of its highest pending source, with a valid flag, so the handler can go straight to that source.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every status, enable and mode bit is zero, every request line and valid flag is low, and every register reads as zero.
- R2: Bank b occupies byte addresses b*0x28 to b*0x28+0x27. Within a bank, status is at 0x00, enable at 0x08, pending at 0x10, set at 0x18 and mode at 0x20. Reads of any other offset, or of any address above the last bank, return zero, and writes to them change nothing.
- R3: A source input that is high at a clock edge sets its status bit at that edge. In latched mode (mode bit 0) the bit stays set after the source drops.
- R4: Writing the status register clears each bit written as one and leaves bits written as zero unchanged. Writing all ones clears the whole bank.
- R5: When a clearing write and a high source input hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing the set register sets each status bit written as one. The set register itself always reads as zero.
- R7: The enable register reads back what was written. The pending register reads as status AND enable, and writes to it are ignored.
- R8: A bank's request line is high in the cycle after its pending word is nonzero and low in the cycle after it is zero. Banks do not affect one another.
- R9: A bank's 5-bit index output gives the position of the highest set pending bit, and its valid flag is high exactly when the pending word is nonzero. Both change in the same cycle as the pending word.
- R10: A source whose mode bit is 1 has a status bit that follows its input. The bit clears at the first edge where the input is low, with no write needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_req | input | 160 | Source request inputs; bank b uses bits b*32 to b*32+31 |
| irq_req | output | 5 | One CPU request line per bank, bank 0 in bit 0 |
| top_idx | output | 25 | Highest pending source per bank, 5 bits per bank |
| top_vld | output | 5 | Per-bank flag that top_idx holds a pending source |

## Verification
The bench builds the block with its default parameters: five banks of 32 sources each and an 8-bit address. With these values the last bank sits at 0xA0, so the stride arithmetic is exercised right up to the top of the map. Addresses past 0xC7 are unmapped and can be probed. Source 31 and source 0 are both reachable, so the index output is tested at both ends of its range. Because all five request lines are visible together, the bench can confirm that activity in one bank leaves the other lines quiet.

// File: rtl/bicu_pkg.sv
`timescale 1ns/1ps
package bicu_pkg;

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_EN   = 3'd1,
    SEL_PEND = 3'd2,
    SEL_SET  = 3'd3,
    SEL_MODE = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned BANK_STRIDE = 40;
  localparam int unsigned OFS_STAT    = 0;
  localparam int unsigned OFS_EN      = 8;
  localparam int unsigned OFS_PEND    = 16;
  localparam int unsigned OFS_SET     = 24;
  localparam int unsigned OFS_MODE    = 32;

endpackage

// File: rtl/bicu_addr_dec.sv
`timescale 1ns/1ps
module bicu_addr_dec
  import bicu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output reg_sel_e          sel_o
);

  logic [31:0] addr_ext;
  logic [31:0] ofs;
  logic        in_range;

  assign addr_ext = 32'(addr_i);

  always_comb begin
    in_range = 1'b0;
    bank_o   = '0;
    ofs      = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if ((addr_ext >= 32'(b * BANK_STRIDE)) &&
          (addr_ext <  32'((b + 1) * BANK_STRIDE))) begin
        in_range = 1'b1;
        bank_o   = BANK_W'(b);
        ofs      = addr_ext - 32'(b * BANK_STRIDE);
      end
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (in_range) begin
      case (ofs)
        32'(OFS_STAT): sel_o = SEL_STAT;
        32'(OFS_EN):   sel_o = SEL_EN;
        32'(OFS_PEND): sel_o = SEL_PEND;
        32'(OFS_SET):  sel_o = SEL_SET;
        32'(OFS_MODE): sel_o = SEL_MODE;
        default:       sel_o = SEL_NONE;
      endcase
    end
  end

  assign hit_o = (sel_o != SEL_NONE);

endmodule

// File: rtl/bicu_prio_enc.sv
`timescale 1ns/1ps
module bicu_prio_enc #(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);

  // Scan upward so the highest set bit is the last one kept.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |vec_i;

endmodule

// File: rtl/bicu_bank.sv
`timescale 1ns/1ps
module bicu_bank
  import bicu_pkg::*;
#(
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              vld_o
);

  logic [SRC_W-1:0] st_q, st_d;
  logic [SRC_W-1:0] en_q;
  logic [SRC_W-1:0] mode_q;
  logic             irq_q, irq_d;
  logic [SRC_W-1:0] pend;
  logic [SRC_W-1:0] wval;
  logic [SRC_W-1:0] clr_mask, set_mask;
  logic             wr_stat, wr_en, wr_set, wr_mode;

  assign wval    = wdata_i[SRC_W-1:0];
  assign wr_stat = we_i && (sel_i == SEL_STAT);
  assign wr_en   = we_i && (sel_i == SEL_EN);
  assign wr_set  = we_i && (sel_i == SEL_SET);
  assign wr_mode = we_i && (sel_i == SEL_MODE);

  // Next state: the sticky part is dropped by a write-one clear or by level
  // mode; sources and the set register are ORed in last, so they win.
  always_comb begin
    clr_mask = wr_stat ? wval : '0;
    set_mask = wr_set  ? wval : '0;
    st_d     = (st_q & ~clr_mask & ~mode_q) | src_i | set_mask;
  end

  assign pend  = st_q & en_q;
  assign irq_d = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      if (wr_en)   en_q   <= wval;
      if (wr_mode) mode_q <= wval;
    end
  end

  always_comb begin
    case (sel_i)
      SEL_STAT: rdata_o = DATA_W'(st_q);
      SEL_EN:   rdata_o = DATA_W'(en_q);
      SEL_PEND: rdata_o = DATA_W'(pend);
      SEL_MODE: rdata_o = DATA_W'(mode_q);
      default:  rdata_o = '0;
    endcase
  end

  bicu_prio_enc #(.W(SRC_W), .IDX_W(IDX_W)) u_enc (
    .vec_i (pend),
    .idx_o (idx_o),
    .vld_o (vld_o)
  );

  assign irq_o = irq_q;

  AST_SRC_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((st_q & $past(src_i)) == $past(src_i))); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((st_q & $past(wval & ~src_i)) == '0)); // R4

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> irq_o); // R8

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq_o); // R8

  AST_IDX_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (pend[idx_o] && (((pend >> idx_o) >> 1) == '0))); // R9

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set |=> ((st_q & $past(mode_q & ~src_i)) == '0)); // R10

endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
  import bicu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned SRC_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_BANKS*SRC_W-1:0] src_req,
  output logic [NUM_BANKS-1:0]       irq_req,
  output logic [NUM_BANKS*IDX_W-1:0] top_idx,
  output logic [NUM_BANKS-1:0]       top_vld
);

  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // Reset synchronizer: assert asynchronously, release on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              dec_hit;
  logic [BANK_W-1:0] dec_bank;
  reg_sel_e          dec_sel;

  bicu_addr_dec #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W)
  ) u_dec (
    .addr_i (reg_addr),
    .hit_o  (dec_hit),
    .bank_o (dec_bank),
    .sel_o  (dec_sel)
  );

  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic bank_we;
    assign bank_we = reg_we && dec_hit && (dec_bank == BANK_W'(b));

    bicu_bank #(
      .SRC_W  (SRC_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src_i   (src_req[b*SRC_W +: SRC_W]),
      .we_i    (bank_we),
      .sel_i   (dec_sel),
      .wdata_i (reg_wdata),
      .rdata_o (bank_rdata[b]),
      .irq_o   (irq_req[b]),
      .idx_o   (top_idx[b*IDX_W +: IDX_W]),
      .vld_o   (top_vld[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (dec_hit && (dec_bank == BANK_W'(b))) reg_rdata = bank_rdata[b];
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (irq_req == '0)); // R1

endmodule

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;

  localparam int NB = 5;
  localparam int SW = 32;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [NB*SW-1:0] src;
  logic [NB-1:0]    irq;
  logic [NB*5-1:0]  idx;
  logic [NB-1:0]    vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  banked_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_req   (src),
    .irq_req   (irq),
    .top_idx   (idx),
    .top_vld   (vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(input int b, input int ofs);
    return 8'(b * 40 + ofs);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset;
    for (int b = 0; b < NB; b++) begin
      rchk("R1 status", ra(b, 0), 0);
      rchk("R1 enable", ra(b, 8), 0);
      rchk("R1 mode", ra(b, 32), 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vld", 32'(vld), 0);
  endtask

  task automatic t_latch;
    @(negedge clk); src[1*32+5] = 1'b1;
    @(negedge clk); src[1*32+5] = 1'b0;
    rchk("R3 latched", ra(1, 0), 32'h20);
    rchk("R7 masked pend", ra(1, 16), 0);
    chk("R8 no irq", 32'(irq), 0);
    wr(ra(1, 8), 32'h20);
    rchk("R7 enable readback", ra(1, 8), 32'h20);
    rchk("R7 pend", ra(1, 16), 32'h20);
    chk("R9 idx", 32'(idx[1*5 +: 5]), 5);
    chk("R9 vld", 32'(vld[1]), 1);
    chk("R8 irq lag", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq raised bank1 only", 32'(irq), 32'h2);
    wr(ra(1, 0), 32'h20);
    rchk("R4 cleared", ra(1, 0), 0);
    chk("R9 vld off", 32'(vld[1]), 0);
    chk("R8 irq fall lag", 32'(irq), 32'h2);
    @(negedge clk);
    chk("R8 irq low", 32'(irq), 0);
    wr(ra(1, 8), 0);
  endtask

  task automatic t_set_reg;
    wr(ra(0, 24), 32'hF0F0_000F);
    rchk("R6 set bits", ra(0, 0), 32'hF0F0_000F);
    rchk("R6 set reads zero", ra(0, 24), 0);
    wr(ra(0, 0), 0);
    rchk("R4 zero write no effect", ra(0, 0), 32'hF0F0_000F);
    wr(ra(0, 0), 32'h0000_000F);
    rchk("R4 partial clear", ra(0, 0), 32'hF0F0_0000);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    rchk("R4 clear all", ra(0, 0), 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    src[2*32+31] = 1'b1;
    reg_we = 1'b1; reg_addr = ra(2, 0); reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_we = 1'b0; src[2*32+31] = 1'b0;
    rchk("R5 set wins", ra(2, 0), 32'h8000_0000);
    wr(ra(2, 0), 32'hFFFF_FFFF);
    rchk("R5 cleared after", ra(2, 0), 0);
  endtask

  task automatic t_prio;
    wr(ra(4, 8), 32'hFFFF_FFFF);
    wr(ra(4, 24), 32'h8002_0008);
    rchk("R2 bank4 pend", ra(4, 16), 32'h8002_0008);
    chk("R9 idx 31", 32'(idx[4*5 +: 5]), 31);
    chk("R9 vld", 32'(vld[4]), 1);
    wr(ra(4, 0), 32'h8000_0000);
    chk("R9 idx 17", 32'(idx[4*5 +: 5]), 17);
    wr(ra(4, 0), 32'h0002_0000);
    chk("R9 idx 3", 32'(idx[4*5 +: 5]), 3);
    wr(ra(4, 0), 32'h0000_0008);
    chk("R9 vld clear", 32'(vld[4]), 0);
    wr(ra(4, 24), 32'h0000_0001);
    chk("R9 idx 0", 32'(idx[4*5 +: 5]), 0);
    chk("R9 vld bit0", 32'(vld[4]), 1);
    @(negedge clk);
    chk("R8 irq bank4", 32'(irq), 32'h10);
    wr(ra(4, 0), 32'h1);
    wr(ra(4, 8), 0);
  endtask

  task automatic t_map;
    wr(ra(0, 24), 32'h3);
    wr(ra(0, 8), 32'h1);
    wr(ra(0, 16), 32'hFFFF_FFFF);
    rchk("R7 pend read-only", ra(0, 16), 32'h1);
    rchk("R7 status kept", ra(0, 0), 32'h3);
    rchk("R7 enable kept", ra(0, 8), 32'h1);
    wr(ra(0, 4), 32'hFFFF_FFFF);
    rchk("R2 hole reads zero", ra(0, 4), 0);
    rchk("R2 hole write ignored", ra(0, 8), 32'h1);
    wr(8'hC8, 32'hFFFF_FFFF);
    rchk("R2 beyond map", 8'hC8, 0);
    rchk("R2 bank4 untouched", ra(4, 0), 0);
    rchk("R2 bank0 untouched", ra(0, 0), 32'h3);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    wr(ra(0, 8), 0);
  endtask

  task automatic t_mode;
    wr(ra(3, 32), 32'h4);
    rchk("R10 mode readback", ra(3, 32), 32'h4);
    @(negedge clk); src[3*32+2] = 1'b1; src[3*32+3] = 1'b1;
    @(negedge clk); src[3*32+2] = 1'b0; src[3*32+3] = 1'b0;
    rchk("R10 both captured", ra(3, 0), 32'hC);
    @(negedge clk);
    rchk("R10 level bit drops", ra(3, 0), 32'h8);
    wr(ra(3, 0), 32'h8);
    rchk("R3 latch cleared", ra(3, 0), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch();
    t_set_reg();
    t_set_wins();
    t_prio();
    t_map();
    t_mode();
    finish_run();
  end

endmodule